// File: doc/BRIEF.md
# Boot Configuration Bits and Zero-Address Remap

This block keeps three boot configuration bits and turns them into the memory map seen at address zero, where the processor always starts fetching. Bit 1 chooses whether the boot ROM or the flash appears at zero. Bit 2 chooses which of the two 256 KB flash banks is the boot bank. Bit 0 is a security flag that the block only holds and shows on an output. Each bit is changed by a single-cycle set or clear command that carries a bit index. An erase strobe returns the boot-mode bit and the bank bit to their safe state, which is ROM boot from bank 0.

The remap and bank choices that the address decoder uses are not the live bits. A separate boot-latch strobe copies the live bits into them, so a fetch in progress never sees the map change. The decoder receives the upper address bits of a fetch. For any address inside the 512 KB window at zero, it raises exactly one of three selects: ROM, bank 0 or bank 1.

Top module: `boot_cfg_remap`

## Requirements
- R1: After reset, cfgBits is 3'b000, and remapFlash, bootBank and cmdErr are 0.
- R2: A command with cmdValid=1, cmdSet=1 and cmdIdx below 3 sets bit cmdIdx of cfgBits. The new value shows after that clock edge, and the other bits keep their values.
- R3: A command with cmdValid=1, cmdSet=0 and cmdIdx below 3 clears bit cmdIdx of cfgBits. The new value shows after that clock edge, and the other bits keep their values.
- R4: A command with cmdIdx of 3 leaves cfgBits unchanged. It raises cmdErr for exactly the one cycle after the command edge. cmdErr is 0 when no command with a bad index came on the previous edge.
- R5: eraseStrobe clears cfgBits[1] and cfgBits[2] on the next edge and leaves cfgBits[0] as it was. When a command arrives on the same edge, the erase wins on bits 1 and 2, and a command on bit 0 still takes effect.
- R6: secureOut always equals cfgBits[0].
- R7: remapFlash and bootBank change only on an edge where bootLatch=1. On that edge they take the values that cfgBits[1] and cfgBits[2] held just before it.
- R8: fetchHi carries address bits [23:18]. When any of fetchHi[5:1] is 1, the address is outside the window and none of selRom, selBank0 or selBank1 is high.
- R9: With remapFlash=0, every address inside the window raises selRom only.
- R10: With remapFlash=1, an address inside the window selects bank (fetchHi[0] XOR bootBank). The result 1 raises selBank1 and the result 0 raises selBank0.
- R11: At most one of selRom, selBank0 and selBank1 is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdSet | input | 1 | 1 = set bit, 0 = clear bit |
| cmdIdx | input | 2 | Index of the configuration bit |
| eraseStrobe | input | 1 | Erase event |
| bootLatch | input | 1 | Copy the live bits into the remap and bank outputs |
| fetchHi | input | 6 | Fetch address bits [23:18] |
| cfgBits | output | 3 | Live configuration bits |
| secureOut | output | 1 | Security bit value |
| remapFlash | output | 1 | Latched map choice: 1 = flash at zero |
| bootBank | output | 1 | Latched boot bank |
| cmdErr | output | 1 | Bad-index pulse |
| selRom | output | 1 | ROM select |
| selBank0 | output | 1 | Flash bank 0 select |
| selBank1 | output | 1 | Flash bank 1 select |

## Verification
A wrong bit in the live configuration register shows on cfgBits on the cycle right after the command or erase that caused it, and a wrong bit 0 also shows on secureOut. A fault in the latched remap or bank state stays hidden until a bootLatch strobe. It then appears in the same cycle on every select that the decoder drives. For that reason the bench sweeps all 64 values of the upper address under each of the four latched states. It also checks that changing the live bits without a strobe leaves the selects unchanged.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam int CFG_BITS = 3;
  localparam int IDX_W    = 2;
  localparam int BIT_SEC  = 0;
  localparam int BIT_BOOT = 1;
  localparam int BIT_BANK = 2;
  localparam logic [CFG_BITS-1:0] ERASE_MASK = (1 << BIT_BOOT) | (1 << BIT_BANK);

  typedef struct packed {
    logic [CFG_BITS-1:0] setMask;
    logic [CFG_BITS-1:0] clrMask;
    logic                erase;
    logic                latch;
  } cfgStrobe_t;
endpackage

// File: rtl/boot_cfg_ctrl.sv
module boot_cfg_ctrl
  import boot_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdSet,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic             eraseStrobe,
  input  logic             bootLatch,
  output cfgStrobe_t       strb,
  output logic             cmdErr
);
  logic [CFG_BITS-1:0] hitMask;
  logic                idxOk;

  assign idxOk = cmdIdx < IDX_W'(CFG_BITS);

  for (genvar i = 0; i < CFG_BITS; i++) begin : g_hit
    assign hitMask[i] = cmdValid && idxOk && (cmdIdx == IDX_W'(i));
  end

  always_comb begin
    strb.setMask = cmdSet ? hitMask : '0;
    strb.clrMask = cmdSet ? '0 : hitMask;
    strb.erase   = eraseStrobe;
    strb.latch   = bootLatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdErr <= 1'b0;
    else       cmdErr <= cmdValid && !idxOk;
  end
endmodule

// File: rtl/boot_cfg_dp.sv
module boot_cfg_dp
  import boot_cfg_pkg::*;
#(
  parameter logic [CFG_BITS-1:0] RESET_BITS = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  cfgStrobe_t          strb,
  output logic [CFG_BITS-1:0] cfgQ,
  output logic                remapQ,
  output logic                bankQ
);
  logic [CFG_BITS-1:0] cfgNext;

  always_comb begin
    cfgNext = (cfgQ | strb.setMask) & ~strb.clrMask;
    if (strb.erase) cfgNext = cfgNext & ~ERASE_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= RESET_BITS;
      remapQ <= RESET_BITS[BIT_BOOT];
      bankQ  <= RESET_BITS[BIT_BANK];
    end else begin
      cfgQ <= cfgNext;
      if (strb.latch) begin
        remapQ <= cfgQ[BIT_BOOT];
        bankQ  <= cfgQ[BIT_BANK];
      end
    end
  end
endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode #(
  parameter int HI_W = 6
) (
  input  logic [HI_W-1:0] fetchHi,
  input  logic            remapFlash,
  input  logic            bootBank,
  output logic            selRom,
  output logic            selBank0,
  output logic            selBank1
);
  logic inWin;
  logic bankPick;

  assign inWin    = (fetchHi[HI_W-1:1] == '0);
  assign bankPick = fetchHi[0] ^ bootBank;
  assign selRom   = inWin && !remapFlash;
  assign selBank0 = inWin && remapFlash && !bankPick;
  assign selBank1 = inWin && remapFlash && bankPick;
endmodule

// File: rtl/boot_cfg_remap.sv
module boot_cfg_remap
  import boot_cfg_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BANK_AW = 18,
  parameter logic [2:0] RESET_BITS = 3'b000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdValid,
  input  logic                      cmdSet,
  input  logic [1:0]                cmdIdx,
  input  logic                      eraseStrobe,
  input  logic                      bootLatch,
  input  logic [ADDR_W-BANK_AW-1:0] fetchHi,
  output logic [2:0]                cfgBits,
  output logic                      secureOut,
  output logic                      remapFlash,
  output logic                      bootBank,
  output logic                      cmdErr,
  output logic                      selRom,
  output logic                      selBank0,
  output logic                      selBank1
);
  localparam int HI_W = ADDR_W - BANK_AW;

  cfgStrobe_t strb;

  boot_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSet(cmdSet),
    .cmdIdx(cmdIdx), .eraseStrobe(eraseStrobe), .bootLatch(bootLatch),
    .strb(strb), .cmdErr(cmdErr)
  );

  boot_cfg_dp #(.RESET_BITS(RESET_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgQ(cfgBits), .remapQ(remapFlash), .bankQ(bootBank)
  );

  boot_addr_decode #(.HI_W(HI_W)) u_dec (
    .fetchHi(fetchHi), .remapFlash(remapFlash), .bootBank(bootBank),
    .selRom(selRom), .selBank0(selBank0), .selBank1(selBank1)
  );

  assign secureOut = cfgBits[BIT_SEC];
endmodule

// File: rtl/boot_cfg_sva.sv
module boot_cfg_sva #(
  parameter int HI_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic            cmdSet,
  input logic [1:0]      cmdIdx,
  input logic            eraseStrobe,
  input logic            bootLatch,
  input logic [HI_W-1:0] fetchHi,
  input logic [2:0]      cfgBits,
  input logic            remapFlash,
  input logic            bootBank,
  input logic            cmdErr,
  input logic            selRom,
  input logic            selBank0,
  input logic            selBank1
);
  p_set_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdSet && cmdIdx == 2'd0) |=> cfgBits[0]);

  p_clear_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdSet && cmdIdx == 2'd0) |=> !cfgBits[0]);

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIdx == 2'd3) |=> (cmdErr && $stable(cfgBits)));

  p_err_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdIdx == 2'd3) |=> !cmdErr);

  p_erase_r5: assert property (@(posedge clk) disable iff (!rstN)
    eraseStrobe |=> (cfgBits[2:1] == 2'b00));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !bootLatch |=> ($stable(remapFlash) && $stable(bootBank)));

  p_latch_take_r7: assert property (@(posedge clk) disable iff (!rstN)
    bootLatch |=> (remapFlash == $past(cfgBits[1]) && bootBank == $past(cfgBits[2])));

  p_out_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fetchHi[HI_W-1:1] != '0) |-> !(selRom || selBank0 || selBank1));

  p_rom_map_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fetchHi[HI_W-1:1] == '0 && !remapFlash) |-> selRom);

  p_onehot_sel_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selRom, selBank0, selBank1}));
endmodule

bind boot_cfg_remap boot_cfg_sva #(.HI_W(ADDR_W - BANK_AW)) u_sva (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSet(cmdSet), .cmdIdx(cmdIdx),
  .eraseStrobe(eraseStrobe), .bootLatch(bootLatch), .fetchHi(fetchHi),
  .cfgBits(cfgBits), .remapFlash(remapFlash), .bootBank(bootBank), .cmdErr(cmdErr),
  .selRom(selRom), .selBank0(selBank0), .selBank1(selBank1)
);

// File: tb/tb_boot_cfg_remap.sv
`timescale 1ns/1ps
module tb_boot_cfg_remap;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0, cmdSet = 1'b0, eraseStrobe = 1'b0, bootLatch = 1'b0;
  logic [1:0] cmdIdx = '0;
  logic [5:0] fetchHi = '0;
  logic [2:0] cfgBits;
  logic       secureOut, remapFlash, bootBank, cmdErr, selRom, selBank0, selBank1;

  int checks = 0;
  int errors = 0;
  logic [2:0] expCfg = '0;
  logic       expRemap = 1'b0, expBank = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  boot_cfg_remap dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdSet(cmdSet), .cmdIdx(cmdIdx),
    .eraseStrobe(eraseStrobe), .bootLatch(bootLatch), .fetchHi(fetchHi),
    .cfgBits(cfgBits), .secureOut(secureOut), .remapFlash(remapFlash),
    .bootBank(bootBank), .cmdErr(cmdErr), .selRom(selRom), .selBank0(selBank0),
    .selBank1(selBank1)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic s, input int idx, input logic er, input logic lt);
    @(negedge clk);
    cmdValid = 1'b1; cmdSet = s; cmdIdx = idx[1:0]; eraseStrobe = er; bootLatch = lt;
    if (lt) begin expRemap = expCfg[1]; expBank = expCfg[2]; end
    if (idx < 3) begin
      if (s) expCfg[idx] = 1'b1; else expCfg[idx] = 1'b0;
    end
    if (er) expCfg[2:1] = 2'b00;
    @(negedge clk);
    cmdValid = 1'b0; eraseStrobe = 1'b0; bootLatch = 1'b0;
  endtask

  task automatic setState(input logic [2:0] v);
    for (int b = 0; b < 3; b++) issue(v[b], b, 1'b0, 1'b0);
  endtask

  task automatic latchNow();
    @(negedge clk);
    bootLatch = 1'b1; expRemap = expCfg[1]; expBank = expCfg[2];
    @(negedge clk);
    bootLatch = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cfg", {5'd0, cfgBits}, 8'd0);
    check("R1 remap/bank/err", {5'd0, remapFlash, bootBank, cmdErr}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R6: sweep every state, index and command kind
    for (int st = 0; st < 8; st++) begin
      for (int idx = 0; idx < 4; idx++) begin
        for (int s = 0; s < 2; s++) begin
          setState(st[2:0]);
          issue(s[0], idx, 1'b0, 1'b0);
          check(s[0] ? "R2 set" : "R3 clear", {5'd0, cfgBits}, {5'd0, expCfg});
          check("R4 err pulse", {7'd0, cmdErr}, {7'd0, (idx == 3)});
          check("R6 secure", {7'd0, secureOut}, {7'd0, expCfg[0]});
          check("R7 no latch", {6'd0, remapFlash, bootBank}, {6'd0, expRemap, expBank});
          @(negedge clk);
          check("R4 err one cycle", {7'd0, cmdErr}, 8'd0);
        end
      end
    end

    // R5 erase alone and with a same-edge command
    for (int st = 0; st < 8; st++) begin
      setState(st[2:0]);
      @(negedge clk);
      eraseStrobe = 1'b1; expCfg[2:1] = 2'b00;
      @(negedge clk);
      eraseStrobe = 1'b0;
      check("R5 erase", {5'd0, cfgBits}, {5'd0, expCfg});
      for (int idx = 0; idx < 3; idx++) begin
        setState(st[2:0]);
        issue(1'b1, idx, 1'b1, 1'b0);
        check("R5 erase with set", {5'd0, cfgBits}, {5'd0, expCfg});
      end
    end

    // R7 R8 R9 R10 R11: every latched state, every upper address value
    for (int ls = 0; ls < 4; ls++) begin
      setState({ls[1], ls[0], 1'b1});
      check("R7 before latch", {6'd0, remapFlash, bootBank}, {6'd0, expRemap, expBank});
      latchNow();
      check("R7 after latch", {6'd0, remapFlash, bootBank}, {6'd0, expRemap, expBank});
      setState({~ls[1], ~ls[0], 1'b0});
      check("R7 held", {6'd0, remapFlash, bootBank}, {6'd0, expRemap, expBank});
      for (int a = 0; a < 64; a++) begin
        logic inW, pick;
        logic [2:0] expSel;
        fetchHi = a[5:0];
        #1;
        inW = (a < 2);
        pick = a[0] ^ expBank;
        expSel = !inW ? 3'b000 : (!expRemap ? 3'b100 : (pick ? 3'b001 : 3'b010));
        check(!inW ? "R8 outside" : (!expRemap ? "R9 rom" : "R10 bank"),
              {5'd0, selRom, selBank0, selBank1}, {5'd0, expSel});
        check("R11 onehot", {7'd0, ($countones({selRom, selBank0, selBank1}) <= 1)}, 8'd1);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule